// File: doc/BRIEF.md
# Bus Master Latency Timer

This block limits how long a bus master may go on bursting on a shared, PCI-style bus after the arbiter has taken its grant away. An 8-bit configuration register sets a time slice in bus clocks. Only the upper five bits can be programmed; the three low bits always read as zero. When the master starts its first transaction after winning the bus, a down-counter is loaded from the register. The counter then counts one step per clock from that frame assertion.

Reaching zero does not stop the burst by itself. The block raises its end-of-burst request only when the slice has run out and the grant is also low. That request tells the master to finish the current data phase, negate frame before the last transfer and give up the bus. While the grant stays high, the master keeps the bus indefinitely. A programmed value of zero turns the timer off, so bursts are unlimited.

Top module: `bus_tenure_timer`

## Requirements
- R1: After reset the register reads 00h, and both `slice_expired` and `burst_stop_req` are 0.
- R2: `cfg_rd_data` returns the last value written through `cfg_wr_en`/`cfg_wr_data`, with bits 2:0 forced to 0. The value is visible in the cycle after the write.
- R3: The counter loads on the clock where `bus_frame` rises for the first time after `bus_gnt` rose (all bus inputs are active high). The loaded value is the register with bits 2:0 cleared. `slice_expired` goes to 1 exactly that many clocks after the load edge: 18h gives 24 clocks and 10h gives 16 clocks.
- R4: A register value of 00h (after masking) disables the timer. A load clears `slice_expired`, which then stays 0, and `burst_stop_req` is never raised.
- R5: Once the count reaches zero it does not wrap, and `slice_expired` stays 1 until the next load.
- R6: While `bus_gnt` is high, `burst_stop_req` stays 0, even after the slice has expired.
- R7: `burst_stop_req` is registered. It is 1 in the cycle after a clock edge where `slice_expired` is 1, `bus_gnt` is 0 and either `bus_frame` or `bus_busy` is 1.
- R8: `burst_stop_req` is 0 in the cycle after a clock edge where both `bus_frame` and `bus_busy` are 0. An idle bus therefore never sees the request, even with the slice expired and the grant low.
- R9: A register write made while a count is running does not change that count. It takes effect at the next load.
- R10: A second rise of `bus_frame` under the same grant does not reload the counter, so an expired slice stays expired.
- R11: If the grant is removed before expiry, `burst_stop_req` stays 0 until the slice expires and rises one clock after `slice_expired` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the slice register |
| cfg_wr_data | input | 8 | Value to write; bits 2:0 are discarded |
| cfg_rd_data | output | 8 | Current register value, bits 2:0 zero |
| bus_gnt | input | 1 | Grant from the arbiter, high while owned |
| bus_frame | input | 1 | High while the master holds frame asserted |
| bus_busy | input | 1 | High while a data phase is still in progress |
| slice_expired | output | 1 | Time slice has run out since the last load |
| burst_stop_req | output | 1 | Request to end the burst and release the bus |

## Verification
Two functions can fall in the same cycle. The expiry of the count can coincide with the loss of the grant, and a reload can coincide with an old expired state. The bench removes the grant several clocks before expiry and checks that the request waits for `slice_expired` and follows it by exactly one clock. It also raises a fresh grant and frame while the previous slice is still expired, and checks that the load clears the flag rather than raising a request. A register write made in the middle of a running count is judged by the expiry cycle of the current slice and of the following one.

// File: rtl/btt_pkg.sv
package btt_pkg;

  localparam int unsigned BTT_REG_W = 8;
  localparam int unsigned BTT_RSV_W = 3;

  typedef enum logic [1:0] {
    TMR_OFF     = 2'd0,
    TMR_RUN     = 2'd1,
    TMR_EXPIRED = 2'd2
  } tmr_state_e;

endpackage

// File: rtl/btt_cfg_reg.sv
module btt_cfg_reg #(
  parameter int unsigned REG_W = btt_pkg::BTT_REG_W,
  parameter int unsigned RSV_W = btt_pkg::BTT_RSV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] slice_val
);

  localparam int unsigned PROG_W = REG_W - RSV_W;

  function automatic logic [REG_W-1:0] mask_low(input logic [REG_W-1:0] raw);
    return {raw[REG_W-1:RSV_W], {RSV_W{1'b0}}};
  endfunction

  logic [PROG_W-1:0] prog_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      prog_q <= '0;
    else if (wr_en)  prog_q <= wr_data[REG_W-1:RSV_W];
  end

  assign slice_val = mask_low({prog_q, {RSV_W{1'b0}}});

endmodule

// File: rtl/btt_tenure_arm.sv
module btt_tenure_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic gnt,
  input  logic frame,
  output logic load_evt
);

  logic gnt_q;
  logic frame_q;
  logic armed_q;
  logic grant_new;
  logic frame_rise;

  assign grant_new  = gnt & ~gnt_q;
  assign frame_rise = frame & ~frame_q;
  assign load_evt   = frame_rise & gnt & (armed_q | grant_new);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q   <= 1'b0;
      frame_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      gnt_q   <= gnt;
      frame_q <= frame;
      armed_q <= gnt & (armed_q | grant_new) & ~load_evt;
    end
  end

endmodule

// File: rtl/btt_slice_counter.sv
module btt_slice_counter
  import btt_pkg::*;
#(
  parameter int unsigned REG_W = BTT_REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_evt,
  input  logic [REG_W-1:0] slice_val,
  output logic [REG_W-1:0] count,
  output logic             expired,
  output tmr_state_e       state
);

  function automatic logic [REG_W-1:0] step_down(input logic [REG_W-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  function automatic logic last_step(input logic [REG_W-1:0] c);
    return c == {{(REG_W-1){1'b0}}, 1'b1};
  endfunction

  logic [REG_W-1:0] count_q;
  tmr_state_e       state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      state_q <= TMR_OFF;
    end else if (load_evt) begin
      count_q <= slice_val;
      state_q <= (slice_val == '0) ? TMR_OFF : TMR_RUN;
    end else if (state_q == TMR_RUN) begin
      count_q <= step_down(count_q);
      if (last_step(count_q)) state_q <= TMR_EXPIRED;
    end
  end

  assign count   = count_q;
  assign state   = state_q;
  assign expired = (state_q == TMR_EXPIRED);

endmodule

// File: rtl/btt_stop_ctl.sv
module btt_stop_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic expired,
  input  logic gnt,
  input  logic frame,
  input  logic busy,
  output logic want_stop,
  output logic bus_quiet,
  output logic stop_req
);

  logic stop_q;

  assign want_stop = expired & ~gnt;
  assign bus_quiet = ~frame & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) stop_q <= 1'b0;
    else        stop_q <= (stop_q | want_stop) & ~bus_quiet;
  end

  assign stop_req = stop_q;

endmodule

// File: rtl/bus_tenure_timer.sv
module bus_tenure_timer
  import btt_pkg::*;
#(
  parameter int unsigned REG_W = BTT_REG_W,
  parameter int unsigned RSV_W = BTT_RSV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wr_data,
  output logic [REG_W-1:0] cfg_rd_data,
  input  logic             bus_gnt,
  input  logic             bus_frame,
  input  logic             bus_busy,
  output logic             slice_expired,
  output logic             burst_stop_req
);

  logic [REG_W-1:0] slice_val;
  logic [REG_W-1:0] count;
  logic             load_evt;
  logic             expired;
  logic             want_stop;
  logic             bus_quiet;
  tmr_state_e       tmr_state;

  btt_cfg_reg #(.REG_W(REG_W), .RSV_W(RSV_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .wr_data   (cfg_wr_data),
    .slice_val (slice_val)
  );

  btt_tenure_arm u_arm (
    .clk      (clk),
    .rst_n    (rst_n),
    .gnt      (bus_gnt),
    .frame    (bus_frame),
    .load_evt (load_evt)
  );

  btt_slice_counter #(.REG_W(REG_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_evt  (load_evt),
    .slice_val (slice_val),
    .count     (count),
    .expired   (expired),
    .state     (tmr_state)
  );

  btt_stop_ctl u_stop (
    .clk       (clk),
    .rst_n     (rst_n),
    .expired   (expired),
    .gnt       (bus_gnt),
    .frame     (bus_frame),
    .busy      (bus_busy),
    .want_stop (want_stop),
    .bus_quiet (bus_quiet),
    .stop_req  (burst_stop_req)
  );

  assign cfg_rd_data   = slice_val;
  assign slice_expired = expired;

endmodule

// File: rtl/btt_checker.sv
module btt_checker #(
  parameter int unsigned REG_W = 8,
  parameter int unsigned RSV_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gnt,
  input logic             frame,
  input logic             busy,
  input logic [REG_W-1:0] rd_data,
  input logic [REG_W-1:0] slice_val,
  input logic [REG_W-1:0] count,
  input logic             load_evt,
  input logic             expired,
  input logic             stop_req
);

  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[RSV_W-1:0] == '0);

  a_r3_load_takes_slice: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> count == $past(slice_val));

  a_r3_count_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && count != '0) |=> count == $past(count) - 1'b1);

  a_r3_expire_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> count == '0);

  a_r4_disabled_no_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && slice_val == '0) |=> !expired);

  a_r5_expired_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load_evt) |=> expired);

  a_r6_grant_blocks_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt && !stop_req) |=> !stop_req);

  a_r7_stop_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !gnt && (frame || busy)) |=> stop_req);

  a_r8_quiet_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame && !busy) |=> !stop_req);

endmodule

bind bus_tenure_timer btt_checker #(.REG_W(REG_W), .RSV_W(RSV_W)) u_btt_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gnt       (bus_gnt),
  .frame     (bus_frame),
  .busy      (bus_busy),
  .rd_data   (cfg_rd_data),
  .slice_val (slice_val),
  .count     (count),
  .load_evt  (load_evt),
  .expired   (slice_expired),
  .stop_req  (burst_stop_req)
);

// File: tb/bus_tenure_timer_tb_top.sv
module bus_tenure_timer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SIG_STOP = 0;
  localparam int SIG_EXP  = 1;
  localparam int SIG_RD   = 2;

  typedef struct {
    int        at;
    int        sig;
    logic [7:0] val;
    string     req;
  } exp_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = '0;
  logic [7:0] cfg_rd_data;
  logic       bus_gnt = 1'b0;
  logic       bus_frame = 1'b0;
  logic       bus_busy = 1'b0;
  logic       slice_expired;
  logic       burst_stop_req;

  int cyc = 0;
  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;
  exp_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_tenure_timer dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr_en      (cfg_wr_en),
    .cfg_wr_data    (cfg_wr_data),
    .cfg_rd_data    (cfg_rd_data),
    .bus_gnt        (bus_gnt),
    .bus_frame      (bus_frame),
    .bus_busy       (bus_busy),
    .slice_expired  (slice_expired),
    .burst_stop_req (burst_stop_req)
  );

  function automatic logic [7:0] masked(input logic [7:0] v);
    return v & 8'hF8;
  endfunction

  task automatic expect_at(input int rel, input int sig, input logic [7:0] val, input string req);
    exp_item_t it;
    it.at = cyc + rel;
    it.sig = sig;
    it.val = val;
    it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: pops items whose cycle has come and compares
  always @(negedge clk) begin
    for (int i = sb_q.size() - 1; i >= 0; i--) begin
      if (sb_q[i].at <= cyc) begin
        logic [7:0] act;
        case (sb_q[i].sig)
          SIG_STOP: act = {7'd0, burst_stop_req};
          SIG_EXP:  act = {7'd0, slice_expired};
          default:  act = cfg_rd_data;
        endcase
        n_checks++;
        if (sb_q[i].at < cyc || act !== sb_q[i].val) begin
          n_errors++;
          $display("FAIL %s sig=%0d actual=%0h expected=%0h cycle=%0d",
                   sb_q[i].req, sb_q[i].sig, act, sb_q[i].val, cyc);
        end
        sb_q.delete(i);
      end
    end
  end

  task automatic drive(input logic g, input logic f, input logic b);
    @(negedge clk);
    bus_gnt = g;
    bus_frame = f;
    bus_busy = b;
  endtask

  task automatic cfg_write(input logic [7:0] v, input string req);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_wr_data = v;
    expect_at(1, SIG_RD, masked(v), req);
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_at(1, SIG_RD, 8'h00, "R1");
    expect_at(1, SIG_EXP, 8'h00, "R1");
    expect_at(1, SIG_STOP, 8'h00, "R1");
    drive(0, 0, 0);

    // R2: low bits dropped
    cfg_write(8'hFF, "R2");
    cfg_write(8'h1D, "R2");

    // R3/R5/R6/R7/R8: slice 18h = 24 clocks
    cfg_write(8'h18, "R2");
    drive(1, 0, 0);
    drive(1, 1, 1);
    expect_at(24, SIG_EXP, 8'h00, "R3");
    expect_at(25, SIG_EXP, 8'h01, "R3");
    expect_at(30, SIG_STOP, 8'h00, "R6");
    expect_at(40, SIG_EXP, 8'h01, "R5");
    repeat (40) drive(1, 1, 1);
    drive(0, 1, 1);
    expect_at(1, SIG_STOP, 8'h01, "R7");
    drive(0, 1, 1);
    drive(0, 0, 1);
    expect_at(1, SIG_STOP, 8'h01, "R8");
    drive(0, 0, 0);
    expect_at(1, SIG_STOP, 8'h00, "R8");
    drive(0, 0, 0);

    // R4: zero disables
    cfg_write(8'h07, "R4");
    drive(1, 0, 0);
    drive(1, 1, 1);
    expect_at(1, SIG_EXP, 8'h00, "R4");
    repeat (10) drive(1, 1, 1);
    repeat (20) drive(0, 1, 1);
    expect_at(1, SIG_STOP, 8'h00, "R4");
    expect_at(1, SIG_EXP, 8'h00, "R4");
    drive(0, 0, 0);

    // R9/R10: write mid-count, re-rise of frame under same grant
    cfg_write(8'h08, "R2");
    drive(1, 0, 0);
    drive(1, 1, 1);
    expect_at(8, SIG_EXP, 8'h00, "R9");
    expect_at(9, SIG_EXP, 8'h01, "R9");
    drive(1, 1, 1);
    cfg_write(8'hF8, "R9");
    repeat (10) drive(1, 1, 1);
    drive(1, 0, 1);
    drive(1, 1, 1);
    expect_at(1, SIG_EXP, 8'h01, "R10");
    expect_at(5, SIG_EXP, 8'h01, "R10");
    repeat (5) drive(1, 1, 1);
    drive(0, 0, 0);
    drive(1, 0, 0);
    drive(1, 1, 1);
    expect_at(1, SIG_EXP, 8'h00, "R9");
    expect_at(248, SIG_EXP, 8'h00, "R9");
    expect_at(249, SIG_EXP, 8'h01, "R9");
    repeat (250) drive(1, 1, 1);
    drive(0, 0, 0);
    expect_at(1, SIG_STOP, 8'h00, "R8");

    // R11: grant dropped before expiry, slice 10h = 16 clocks
    cfg_write(8'h10, "R2");
    drive(1, 0, 0);
    drive(1, 1, 1);
    expect_at(16, SIG_EXP, 8'h00, "R3");
    expect_at(17, SIG_EXP, 8'h01, "R3");
    expect_at(17, SIG_STOP, 8'h00, "R11");
    expect_at(18, SIG_STOP, 8'h01, "R11");
    repeat (4) drive(1, 1, 1);
    repeat (20) drive(0, 1, 1);
    drive(0, 0, 0);
    expect_at(1, SIG_STOP, 8'h00, "R8");
    repeat (5) drive(0, 0, 0);
    expect_at(1, SIG_STOP, 8'h00, "R8");
    expect_at(1, SIG_EXP, 8'h01, "R5");

    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_errors += sb_q.size();
      n_checks += sb_q.size();
      $display("FAIL scoreboard: %0d expected items never compared (expected 0)", sb_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: run did not end (actual hung, expected finished)");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule